// File: doc/BRIEF.md
# Register-to-register ALU instruction executor

This block runs the one-byte register instructions of a small 16-bit processor. It holds four 16-bit general registers and a set of four status flags: N (negative), Z (zero), V (signed overflow) and C (carry or borrow). Each strobed opcode is decoded into an operation group, a destination field and a source field. The result is computed in a single cycle, and the destination register and the flags are written at the next rising clock edge.

Opcodes whose two register fields are equal do not use the binary meaning of their group; they select a single-operand operation instead. The quick-add group uses the source field to pick a small signed constant. A combinational debug port reads any register, so the whole state can be seen from outside the block.

Top module: `rr_alu_exec`

## Requirements
- R1: While rst_n is low, all four registers and all four flags are cleared to zero.
- R2: When op_valid is high and op_code[7] is 0, op_code[6:4] selects the group (0 move, 1 and, 2 xor, 3 or, 4 add, 5 quick add, 6 sub, 7 compare). op_code[1:0] names the destination and op_code[3:2] names the source. A move with different fields copies the source into the destination at the next rising edge.
- R3: Move, and, xor and or set N to bit 15 of the result and Z to (result == 0), and they clear V and C.
- R4: With equal fields, group 0 writes the low byte of the register sign-extended to 16 bits, and group 3 writes its bitwise inverse. Group 1 sets N and Z from the register value, clears V and C, and writes no register.
- R5: With equal fields, xor clears the register and sets Z. Add doubles the register, with add flags.
- R6: Add writes dst+src. C is the carry out of bit 15, and V is set when the signed sum falls outside the 16-bit range.
- R7: Quick add adds a constant to the register named by op_code[1:0]. op_code[3:2] chooses the constant: 00 gives +2, 01 gives +1, 10 gives -2, 11 gives -1. C is the carry out of adding the constant's 16-bit two's-complement code, and V flags signed overflow.
- R8: Sub writes dst-src. C is set when src > dst as unsigned values (a borrow), and V is set on signed overflow.
- R9: With equal fields, group 6 writes 0-reg. C is set when reg is not zero, and V is set when reg is 0x8000.
- R10: Compare with different fields sets the flags exactly as sub would, and writes no register.
- R11: With equal fields, group 7 writes the absolute value. 0x8000 gives 0x8000 with V set. C is set when the operand was negative. N and Z follow the result.
- R12: A cycle with op_valid low, or with op_code[7] high, changes no register and no flag.
- R13: dbg_data shows the register selected by dbg_sel, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Instruction byte |
| dbg_sel | input | 2 | Register select for debug read |
| dbg_data | output | 16 | Selected register value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The hardest states to reach are the ones that need a particular operand, such as 0x8000 for absolute value and negate, or 0x7FFF for signed overflow on add. No port loads a register directly. The bench reaches these values by building them inside the block: it clears a register with a self-xor, then forms the value bit by bit with self-add doublings and +1 quick adds. It then applies the directed corner opcodes. Long random opcode streams, including idle cycles and opcodes with bit 7 set, are checked after every cycle against a reference model kept in the bench.

// File: rtl/rr_alu_exec.sv
module rr_alu_exec #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [7:0]   op_code,
  input  logic [1:0]   dbg_sel,
  output logic [W-1:0] dbg_data,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c
);
  localparam int HALF = W / 2;

  logic [3:0][W-1:0] rf;

  wire [2:0] grp   = op_code[6:4];
  wire [1:0] dst   = op_code[1:0];
  wire [1:0] src   = op_code[3:2];
  wire       unary = (dst == src);
  wire       fire  = op_valid && !op_code[7];

  wire [W-1:0] dv = rf[dst];
  wire [W-1:0] sv = rf[src];

  logic [W-1:0] a_in, b_in, qk, res;
  logic         do_sub, is_arith;

  always_comb begin
    case (src)
      2'b00:   qk = W'(2);
      2'b01:   qk = W'(1);
      2'b10:   qk = {{(W-2){1'b1}}, 2'b10};
      default: qk = {W{1'b1}};
    endcase
  end

  always_comb begin
    a_in   = dv;
    b_in   = sv;
    do_sub = 1'b0;
    case (grp)
      3'd5: b_in = qk;
      3'd6: begin
        do_sub = 1'b1;
        if (unary) begin a_in = '0; b_in = dv; end
      end
      3'd7: begin
        do_sub = 1'b1;
        if (unary) begin
          if (dv[W-1]) begin a_in = '0; b_in = dv; end
          else begin b_in = '0; do_sub = 1'b0; end
        end
      end
      default: ;
    endcase
  end

  wire [W-1:0] b_eff = do_sub ? ~b_in : b_in;
  wire [W:0]   sum   = {1'b0, a_in} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
  wire         c_out = do_sub ? ~sum[W] : sum[W];
  wire         v_out = (a_in[W-1] == b_eff[W-1]) && (sum[W-1] != a_in[W-1]);

  assign is_arith = grp[2];

  always_comb begin
    case (grp)
      3'd0:    res = unary ? {{HALF{dv[HALF-1]}}, dv[HALF-1:0]} : sv;
      3'd1:    res = dv & sv;
      3'd2:    res = dv ^ sv;
      3'd3:    res = unary ? ~dv : (dv | sv);
      default: res = sum[W-1:0];
    endcase
  end

  wire wr_en = fire && !(grp == 3'd7 && !unary) && !(grp == 3'd1 && unary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf     <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_v <= 1'b0;
      flag_c <= 1'b0;
    end else if (fire) begin
      if (wr_en) rf[dst] <= res;
      flag_n <= res[W-1];
      flag_z <= (res == '0);
      flag_v <= is_arith && v_out;
      flag_c <= is_arith && c_out;
    end
  end

  assign dbg_data = rf[dbg_sel];

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(rf) && $stable({flag_n, flag_z, flag_v, flag_c})); // R12
  AST_HIGH_OPCODE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code[7] |=> $stable(rf) && $stable({flag_n, flag_z, flag_v, flag_c})); // R12
  AST_COMPARE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && grp == 3'd7 && !unary |=> $stable(rf)); // R10
  AST_TEST_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    fire && grp == 3'd1 && unary |=> $stable(rf) && !flag_v && !flag_c); // R4
  AST_LOGIC_CLEARS_VC: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !grp[2] |=> !flag_v && !flag_c); // R3
  AST_Z_MATCHES_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> flag_z == (rf[$past(op_code[1:0])] == '0)); // R2
  AST_XOR_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire && grp == 3'd2 && unary |=> rf[$past(op_code[1:0])] == '0 && flag_z); // R5
  AST_ABS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    fire && grp == 3'd7 && unary |=> !rf[$past(op_code[1:0])][W-1] || flag_v); // R11
endmodule

// File: tb/rr_alu_exec_tb_top.sv
`timescale 1ns/1ps
module rr_alu_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic [1:0]  dbg_sel = 2'd0;
  logic [15:0] dbg_data;
  logic        flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mr [4];
  bit mn, mz, mv, mc;

  always #2.5 clk = ~clk;

  rr_alu_exec dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic int sgn(int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic bit ovf(int v);
    return (v > 32767) || (v < -32768);
  endfunction

  function automatic string tag_of(logic [7:0] op, bit v);
    bit u = (op[1:0] == op[3:2]);
    if (!v || op[7]) return "R12";
    case (op[6:4])
      3'd0: return u ? "R4" : "R2";
      3'd1: return u ? "R4" : "R3";
      3'd2: return u ? "R5" : "R3";
      3'd3: return u ? "R4" : "R3";
      3'd4: return u ? "R5" : "R6";
      3'd5: return "R7";
      3'd6: return u ? "R9" : "R8";
      default: return u ? "R11" : "R10";
    endcase
  endfunction

  task automatic model_exec(input logic [7:0] op);
    int d = op[1:0];
    int s = op[3:2];
    int x = mr[d];
    int y = mr[s];
    int r = 0;
    int k = 0;
    bit wr = 1;
    bit u = (d == s);
    mv = 0; mc = 0;
    case (op[6:4])
      3'd0: r = u ? (((x & 128) != 0) ? ((x & 255) | 32'hFF00) : (x & 255)) : y;
      3'd1: begin r = x & y; if (u) wr = 0; end
      3'd2: r = x ^ y;
      3'd3: r = u ? ((~x) & 32'hFFFF) : (x | y);
      3'd4: begin
        r = x + y; mc = (r > 65535); mv = ovf(sgn(x) + sgn(y)); r = r & 32'hFFFF;
      end
      3'd5: begin
        case (s) 0: k = 2; 1: k = 1; 2: k = -2; default: k = -1; endcase
        r = x + (k & 32'hFFFF); mc = (r > 65535); mv = ovf(sgn(x) + k); r = r & 32'hFFFF;
      end
      3'd6: begin
        if (u) begin r = (65536 - x) & 32'hFFFF; mc = (x != 0); mv = (x == 32768); end
        else begin r = (x - y) & 32'hFFFF; mc = (x < y); mv = ovf(sgn(x) - sgn(y)); end
      end
      default: begin
        if (u) begin
          if (x >= 32768) begin r = (65536 - x) & 32'hFFFF; mc = 1; mv = (x == 32768); end
          else r = x;
        end else begin
          r = (x - y) & 32'hFFFF; mc = (x < y); mv = ovf(sgn(x) - sgn(y)); wr = 0;
        end
      end
    endcase
    mn = (r >= 32768);
    mz = (r == 0);
    if (wr) mr[d] = r;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    for (int i = 0; i < 4; i++) begin
      dbg_sel = 2'(i);
      #0.2;
      chk(tag, int'(dbg_data), mr[i]);
    end
    chk(tag, int'({flag_n, flag_z, flag_v, flag_c}), int'({mn, mz, mv, mc}));
  endtask

  task automatic do_op(input logic [7:0] op, input bit v = 1);
    @(negedge clk);
    op_code = op;
    op_valid = v;
    @(posedge clk);
    #0.5;
    op_valid = 1'b0;
    if (v && !op[7]) model_exec(op);
    check_state(tag_of(op, v));
  endtask

  task automatic set_reg(input int idx, input logic [15:0] val);
    bit started = 0;
    do_op(8'(8'h20 | (idx << 2) | idx));
    for (int b = 15; b >= 0; b--) begin
      if (started) do_op(8'(8'h40 | (idx << 2) | idx));
      if (val[b]) begin
        do_op(8'(8'h54 | idx));
        started = 1;
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    for (int i = 0; i < 4; i++) mr[i] = 0;
    {mn, mz, mv, mc} = 4'b0;
    op_valid = 1'b1;
    op_code = 8'h4D;
    repeat (3) @(posedge clk);
    #1;
    check_state("R1");
    @(negedge clk);
    op_valid = 1'b0;
    rst_n = 1'b1;

    // R13: distinct values read back through the debug port
    set_reg(0, 16'h1234); set_reg(1, 16'hA5C3); set_reg(2, 16'h0F80); set_reg(3, 16'h8001);
    check_state("R13");
    do_op(8'h01);
    chk("R2", mr[1], 32'h1234);
    do_op(8'h0A);
    chk("R4", mr[2], 32'hFF80);

    // R6: signed overflow then carry to zero
    set_reg(1, 16'h7FFF); set_reg(2, 16'h0001);
    do_op(8'h49);
    chk("R6", int'({flag_v, flag_c, flag_n}), 3'b101);
    set_reg(0, 16'hFFFF); set_reg(3, 16'h0001);
    do_op(8'h4C);
    chk("R6", int'({flag_z, flag_c, flag_v}), 3'b110);

    // R8 / R10: borrow on sub and compare
    set_reg(0, 16'h0000); set_reg(1, 16'h0005);
    do_op(8'h74);
    chk("R10", mr[0], 0);
    do_op(8'h64);
    chk("R8", mr[0], 32'hFFFB);
    chk("R8", int'(flag_c), 1);

    // R9: negate zero and the most negative value
    set_reg(2, 16'h0000);
    do_op(8'h6A);
    chk("R9", int'({flag_z, flag_c, flag_v}), 3'b100);
    set_reg(2, 16'h8000);
    do_op(8'h6A);
    chk("R9", int'({flag_v, flag_c}), 2'b11);

    // R11: absolute value of 0x8000 and of a plain negative
    set_reg(3, 16'h8000);
    do_op(8'h7F);
    chk("R11", mr[3], 32'h8000);
    chk("R11", int'({flag_v, flag_c, flag_n}), 3'b111);
    set_reg(3, 16'hFFFD);
    do_op(8'h7F);
    chk("R11", mr[3], 3);

    // R4 test, R3 invert, R7 each quick constant
    do_op(8'h15);
    do_op(8'h35);
    for (int q = 0; q < 4; q++) do_op(8'(8'h50 | (q << 2) | 1));

    // R12: ignored strobes
    do_op(8'hC7);
    do_op(8'h35, 0);

    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 99);
      logic [7:0] op = 8'($urandom_range(0, 127));
      if (sel < 8) do_op(op | 8'h80);
      else if (sel < 14) do_op(op, 0);
      else do_op(op);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule